// File: doc/BRIEF.md
# Instruction Miss Handler with Line Merging

This block sits beside the instruction cache of a fine-grained multithreaded fetch unit. When a hardware thread misses in the cache, the block puts that thread to sleep by setting its bit in a wait mask. It records the missing line and later fetches that line from memory. When the line returns, the block hands it to the cache and wakes every thread that was waiting for it. A thread may fetch only while it is awake, enabled and has room in its instruction buffer. The `fetch_ok` vector carries that decision to the thread picker.

Memory traffic goes out one line at a time. A pending queue keeps one entry per distinct line address, and each entry carries a bitmap of the threads waiting on that line. A thread that misses on a line already pending joins that entry. This holds for the line currently in flight too. Threads that miss on the same new line in the same cycle are grouped into one entry. A line is therefore never requested twice while it is pending.

A three-state controller runs the fetches. In `IDLE` it offers the oldest pending line to memory and moves to `WAIT_RSP` once the request is accepted. In `WAIT_RSP` it captures the returned line on the response strobe and moves to `WAKE`. In `WAKE` it pulses the cache fill, releases the entry's threads and returns to `IDLE`.

Top module: `icache_miss_merger`

## Requirements
- R1: After reset the wait mask is all zero, `mem_req_valid` is low and `fill_valid` is low.
- R2: `fetch_ok[i]` equals `thread_en[i] & ~ibuf_full[i] & ~wait_mask[i]` in the same cycle.
- R3: A miss is accepted when `miss_valid[i]` is high and `wait_mask[i]` is low. An accepted miss sets `wait_mask[i]` from the next cycle. A miss from a thread whose wait bit is already set is ignored: it creates no entry and no request.
- R4: At most one memory read is outstanding. `mem_req_valid` is high only in `IDLE` while a line is pending. Until `mem_req_ready`, the request stays up with `mem_req_addr` unchanged, and it drops in the cycle after the handshake.
- R5: Lines are requested in the order their first miss was accepted. New lines accepted in the same cycle are ordered by ascending thread index.
- R6: A miss to a line that is already pending, including the line in flight, adds its thread to that entry and creates no new request. Same-cycle misses to one new line form a single entry.
- R7: `mem_rsp_valid` is acted on only in `WAIT_RSP`. The captured 512-bit line appears on `fill_data`, with its address on `fill_addr`, during a `fill_valid` pulse exactly one cycle long in the cycle after the response.
- R8: In the `WAKE` cycle every thread in the entry's bitmap has its wait bit cleared from the next cycle. A miss to that same line arriving in the `WAKE` cycle is woken with it and never sleeps.
- R9: The queue holds as many entries as there are threads and never overflows, even when every thread misses on a distinct line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | NUM_THREADS | Per-thread miss strobe |
| miss_line | input | NUM_THREADS x LINE_ADDR_W | Per-thread missing line address |
| thread_en | input | NUM_THREADS | Thread enabled for fetch |
| ibuf_full | input | NUM_THREADS | Instruction buffer of the thread is full |
| fetch_ok | output | NUM_THREADS | Thread may be picked for fetch |
| wait_mask | output | NUM_THREADS | Thread asleep on an instruction miss |
| mem_req_valid | output | 1 | Line read request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | LINE_ADDR_W | Line address of the request |
| mem_rsp_valid | input | 1 | Memory returns the line |
| mem_rsp_data | input | LINE_BITS | Returned line |
| fill_valid | output | 1 | One-cycle cache fill strobe |
| fill_addr | output | LINE_ADDR_W | Line address being filled |
| fill_data | output | LINE_BITS | Line contents being filled |

## Verification
The bench builds the block with its defaults: four threads, 26-bit line addresses and 512-bit lines. With four threads, each thread missing on its own line fills the queue to its limit. Random traffic draws line addresses from a pool of only three, so same-cycle grouping and joins onto the in-flight line happen constantly, alongside stalled memory handshakes and response strobes outside `WAIT_RSP`. Directed phases pin down a join in the `WAKE` cycle, a repeat miss from a sleeping thread, and the number of memory reads issued for each merge pattern.

// File: rtl/icmm_pkg.sv
package icmm_pkg;
    typedef enum logic [1:0] {
        CTL_IDLE     = 2'd0,
        CTL_WAIT_RSP = 2'd1,
        CTL_WAKE     = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/imh_wait_mask.sv
module imh_wait_mask #(
    parameter int NT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] sleep_map,
    input  logic [NT-1:0] wake_map,
    input  logic [NT-1:0] thread_en,
    input  logic [NT-1:0] ibuf_full,
    output logic [NT-1:0] wait_mask,
    output logic [NT-1:0] fetch_ok
);
    logic [NT-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (!rst_n) wait_q <= '0;
        else        wait_q <= (wait_q | sleep_map) & ~wake_map;
    end

    assign wait_mask = wait_q;
    assign fetch_ok  = ~wait_q & thread_en & ~ibuf_full;

    // R8: every released thread is awake on the following cycle
    assert_wake_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|wake_map) |=> ((wait_q & $past(wake_map)) == '0));

    // R3: an accepted miss that is not released at once leaves the thread asleep
    assert_sleep_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sleep_map & ~wake_map)) |=>
        ((wait_q & $past(sleep_map & ~wake_map)) == $past(sleep_map & ~wake_map)));
endmodule

// File: rtl/imh_pend_queue.sv
module imh_pend_queue #(
    parameter int NT = 4,
    parameter int AW = 26
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NT-1:0]        miss_valid,
    input  logic [NT-1:0][AW-1:0] miss_line,
    input  logic [NT-1:0]        wait_mask,
    input  logic                 pop,
    output logic                 head_valid,
    output logic [AW-1:0]        head_addr,
    output logic [NT-1:0]        sleep_map,
    output logic [NT-1:0]        wake_map
);
    localparam int PW = (NT > 1) ? $clog2(NT) : 1;
    localparam int CW = $clog2(NT + 1);

    logic [AW-1:0] ent_addr_q [NT];
    logic [NT-1:0] ent_map_q  [NT];
    logic [AW-1:0] ent_addr_d [NT];
    logic [NT-1:0] ent_map_d  [NT];
    logic [PW-1:0] head_q, head_d;
    logic [CW-1:0] cnt_q, cnt_d;

    logic [NT-1:0] acc, occ, joined, leader;
    logic [NT-1:0] hit_slot [NT];
    logic [PW-1:0] new_slot [NT];
    logic [PW-1:0] tgt_slot [NT];
    int            lead_idx [NT];
    int            nlead;

    function automatic logic [PW-1:0] wrap_idx(input int v);
        return PW'(v % NT);
    endfunction

    assign acc = miss_valid & ~wait_mask;

    // slot occupancy and per-thread address match
    for (genvar s = 0; s < NT; s++) begin : g_slot
        assign occ[s] = ((s + NT - int'(head_q)) % NT) < int'(cnt_q);
        for (genvar i = 0; i < NT; i++) begin : g_thr
            assign hit_slot[i][s] = acc[i] && occ[s] && (ent_addr_q[s] == miss_line[i]);
        end
    end

    for (genvar i = 0; i < NT; i++) begin : g_join
        assign joined[i] = |hit_slot[i];
    end

    // group fresh misses by line, lowest thread leads, leaders take slots in order
    always_comb begin
        int rank;
        bit found;
        rank  = 0;
        nlead = 0;
        for (int i = 0; i < NT; i++) begin
            found       = 1'b0;
            lead_idx[i] = i;
            leader[i]   = acc[i] & ~joined[i];
            for (int j = 0; j < i; j++) begin
                if (!found && acc[j] && !joined[j] && (miss_line[j] == miss_line[i])) begin
                    found       = 1'b1;
                    lead_idx[i] = j;
                    leader[i]   = 1'b0;
                end
            end
            new_slot[i] = wrap_idx(int'(head_q) + int'(cnt_q) + rank);
            if (leader[i]) rank = rank + 1;
        end
        nlead = rank;
        for (int i = 0; i < NT; i++) begin
            tgt_slot[i] = new_slot[lead_idx[i]];
            for (int s = 0; s < NT; s++) begin
                if (hit_slot[i][s]) tgt_slot[i] = PW'(s);
            end
        end
    end

    // next queue contents
    always_comb begin
        for (int s = 0; s < NT; s++) begin
            ent_addr_d[s] = ent_addr_q[s];
            ent_map_d[s]  = ent_map_q[s];
        end
        for (int i = 0; i < NT; i++) begin
            if (leader[i]) begin
                ent_addr_d[new_slot[i]] = miss_line[i];
                ent_map_d[new_slot[i]]  = '0;
            end
        end
        for (int i = 0; i < NT; i++) begin
            if (acc[i]) ent_map_d[tgt_slot[i]][i] = 1'b1;
        end
        wake_map = pop ? ent_map_d[head_q] : '0;
        head_d   = pop ? wrap_idx(int'(head_q) + 1) : head_q;
        cnt_d    = CW'(int'(cnt_q) + nlead - int'(pop));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            cnt_q  <= '0;
            for (int s = 0; s < NT; s++) begin
                ent_addr_q[s] <= '0;
                ent_map_q[s]  <= '0;
            end
        end else begin
            head_q <= head_d;
            cnt_q  <= cnt_d;
            for (int s = 0; s < NT; s++) begin
                ent_addr_q[s] <= ent_addr_d[s];
                ent_map_q[s]  <= ent_map_d[s];
            end
        end
    end

    assign head_valid = (cnt_q != '0);
    assign head_addr  = ent_addr_q[head_q];
    assign sleep_map  = acc;

    // R9: occupancy after this cycle's pushes and pop stays within depth
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt_q) + nlead - int'(pop)) <= NT);

    // R8: a release only happens while an entry is pending
    assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0));
endmodule

// File: rtl/imh_ctrl.sv
module imh_ctrl
    import icmm_pkg::*;
#(
    parameter int AW = 26,
    parameter int LW = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          head_valid,
    input  logic [AW-1:0] head_addr,
    input  logic          mem_req_ready,
    input  logic          mem_rsp_valid,
    input  logic [LW-1:0] mem_rsp_data,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    output logic          pop,
    output logic          fill_valid,
    output logic [AW-1:0] fill_addr,
    output logic [LW-1:0] fill_data
);
    ctl_state_e state_q, state_d;
    logic [LW-1:0] line_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CTL_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                            line_q <= '0;
        else if (state_q == CTL_WAIT_RSP && mem_rsp_valid)     line_q <= mem_rsp_data;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_IDLE:     if (head_valid && mem_req_ready) state_d = CTL_WAIT_RSP;
            CTL_WAIT_RSP: if (mem_rsp_valid)               state_d = CTL_WAKE;
            CTL_WAKE:                                      state_d = CTL_IDLE;
            default:                                       state_d = CTL_IDLE;
        endcase
    end

    always_comb begin
        mem_req_valid = 1'b0;
        pop           = 1'b0;
        fill_valid    = 1'b0;
        unique case (state_q)
            CTL_IDLE:     mem_req_valid = head_valid;
            CTL_WAIT_RSP: ;
            CTL_WAKE: begin
                fill_valid = 1'b1;
                pop        = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_req_addr = head_addr;
    assign fill_addr    = head_addr;
    assign fill_data    = line_q;

    // R4: an unaccepted request stays up with the same address
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R4: after a handshake no second read is offered
    assert_one_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R7: a fill strobe lasts one cycle
    assert_fill_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid);

    // R7: the captured line is presented on the next cycle
    assert_fill_follows_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTL_WAIT_RSP && mem_rsp_valid) |=> (fill_valid && fill_data == $past(mem_rsp_data)));
endmodule

// File: rtl/icache_miss_merger.sv
module icache_miss_merger #(
    parameter int NUM_THREADS = 4,
    parameter int LINE_ADDR_W = 26,
    parameter int LINE_BITS   = 512
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_THREADS-1:0]                 miss_valid,
    input  logic [NUM_THREADS-1:0][LINE_ADDR_W-1:0] miss_line,
    input  logic [NUM_THREADS-1:0]                 thread_en,
    input  logic [NUM_THREADS-1:0]                 ibuf_full,
    output logic [NUM_THREADS-1:0]                 fetch_ok,
    output logic [NUM_THREADS-1:0]                 wait_mask,
    output logic                                   mem_req_valid,
    input  logic                                   mem_req_ready,
    output logic [LINE_ADDR_W-1:0]                 mem_req_addr,
    input  logic                                   mem_rsp_valid,
    input  logic [LINE_BITS-1:0]                   mem_rsp_data,
    output logic                                   fill_valid,
    output logic [LINE_ADDR_W-1:0]                 fill_addr,
    output logic [LINE_BITS-1:0]                   fill_data
);
    logic                   head_valid;
    logic [LINE_ADDR_W-1:0] head_addr;
    logic [NUM_THREADS-1:0] sleep_map, wake_map;
    logic                   pop;

    imh_pend_queue #(.NT(NUM_THREADS), .AW(LINE_ADDR_W)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_valid (miss_valid),
        .miss_line  (miss_line),
        .wait_mask  (wait_mask),
        .pop        (pop),
        .head_valid (head_valid),
        .head_addr  (head_addr),
        .sleep_map  (sleep_map),
        .wake_map   (wake_map)
    );

    imh_ctrl #(.AW(LINE_ADDR_W), .LW(LINE_BITS)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .head_valid    (head_valid),
        .head_addr     (head_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .pop           (pop),
        .fill_valid    (fill_valid),
        .fill_addr     (fill_addr),
        .fill_data     (fill_data)
    );

    imh_wait_mask #(.NT(NUM_THREADS)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_map (sleep_map),
        .wake_map  (wake_map),
        .thread_en (thread_en),
        .ibuf_full (ibuf_full),
        .wait_mask (wait_mask),
        .fetch_ok  (fetch_ok)
    );

    // R2: a sleeping thread is never offered for fetch
    assert_no_fetch_asleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ok & wait_mask) == '0);
endmodule

// File: tb/icache_miss_merger_tb.sv
module icache_miss_merger_tb;
    localparam int NT = 4;
    localparam int AW = 26;
    localparam int LW = 512;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NT-1:0]     miss_v = '0;
    logic [NT-1:0][AW-1:0] miss_l = '0;
    logic [NT-1:0]     en = '1;
    logic [NT-1:0]     full = '0;
    logic [NT-1:0]     fetch_ok, wait_mask;
    logic              mem_req_valid, fill_valid;
    logic              req_rdy = 1'b0;
    logic              rsp_v = 1'b0;
    logic [AW-1:0]     mem_req_addr, fill_addr;
    logic [LW-1:0]     rsp_d = '0;
    logic [LW-1:0]     fill_data;

    always #2 clk = ~clk;

    icache_miss_merger #(.NUM_THREADS(NT), .LINE_ADDR_W(AW), .LINE_BITS(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_v), .miss_line(miss_l),
        .thread_en(en), .ibuf_full(full), .fetch_ok(fetch_ok), .wait_mask(wait_mask),
        .mem_req_valid(mem_req_valid), .mem_req_ready(req_rdy), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(rsp_v), .mem_rsp_data(rsp_d),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data)
    );

    typedef struct { logic [AW-1:0] a; logic [NT-1:0] m; } ent_t;
    ent_t          mq[$];
    int            mst = 0;
    logic [NT-1:0] mwait = '0;
    logic [LW-1:0] mline = '0;

    int n_chk = 0, n_bad = 0, n_req = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [NT-1:0] exp_ok;
        bit            exp_req, exp_fill;
        exp_ok   = ~mwait & en & ~full;
        exp_req  = (mst == 0) && (mq.size() > 0);
        exp_fill = (mst == 2);
        chk(wait_mask == mwait, "R3,R8", "wait_mask", LW'(wait_mask), LW'(mwait));
        chk(fetch_ok == exp_ok, "R2", "fetch_ok", LW'(fetch_ok), LW'(exp_ok));
        chk(mem_req_valid == exp_req, "R4", "mem_req_valid", LW'(mem_req_valid), LW'(exp_req));
        if (exp_req && mem_req_valid)
            chk(mem_req_addr == mq[0].a, "R5,R6", "mem_req_addr", LW'(mem_req_addr), LW'(mq[0].a));
        chk(fill_valid == exp_fill, "R7", "fill_valid", LW'(fill_valid), LW'(exp_fill));
        if (exp_fill && fill_valid) begin
            chk(fill_addr == mq[0].a, "R7", "fill_addr", LW'(fill_addr), LW'(mq[0].a));
            chk(fill_data == mline, "R7", "fill_data", fill_data, mline);
        end
    endtask

    // behavioural reference: one call per clock, using the inputs about to be sampled
    task automatic model_step();
        logic [NT-1:0] acc, wk;
        bit            had;
        bit            found;
        ent_t          e;
        had = mq.size() > 0;
        acc = miss_v & ~mwait;
        wk  = '0;
        for (int i = 0; i < NT; i++) begin
            if (acc[i]) begin
                found = 0;
                for (int k = 0; k < mq.size(); k++)
                    if (!found && mq[k].a == miss_l[i]) begin
                        mq[k].m[i] = 1'b1;
                        found = 1;
                    end
                if (!found) begin
                    e.a = miss_l[i];
                    e.m = NT'(1) << i;
                    mq.push_back(e);
                end
            end
        end
        case (mst)
            0: if (had && req_rdy) mst = 1;
            1: if (rsp_v) begin mline = rsp_d; mst = 2; end
            default: begin wk = mq[0].m; void'(mq.pop_front()); mst = 0; end
        endcase
        mwait = (mwait | acc) & ~wk;
    endtask

    task automatic tick();
        if (mem_req_valid && req_rdy) n_req++;
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic rand_rsp();
        logic [31:0] r;
        for (int w = 0; w < LW / 32; w++) begin
            r = $urandom;
            rsp_d[w*32 +: 32] = r;
        end
    endtask

    initial begin
        int base;
        logic [31:0] r1, r2;
        logic [AW-1:0] pool [3];
        pool[0] = 26'h0000040; pool[1] = 26'h1ABCDE5; pool[2] = 26'h3FFFFFF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(wait_mask == '0, "R1", "wait_mask after reset", LW'(wait_mask), '0);
        chk(!mem_req_valid, "R1", "mem_req_valid after reset", LW'(mem_req_valid), '0);
        chk(!fill_valid, "R1", "fill_valid after reset", LW'(fill_valid), '0);
        compare();

        // R6, R5: threads 0 and 2 share line A, thread 1 wants B, same cycle
        base = n_req;
        req_rdy = 1'b1; rsp_v = 1'b0;
        miss_v = 4'b0111;
        miss_l[0] = 26'h0000100; miss_l[1] = 26'h0000200; miss_l[2] = 26'h0000100;
        tick();
        miss_v = '0;
        repeat (3) tick();
        // R6: thread 3 joins the line already in flight
        miss_v = 4'b1000; miss_l[3] = 26'h0000100;
        tick();
        miss_v = '0; rsp_v = 1'b1; rand_rsp();
        repeat (12) tick();
        chk((n_req - base) == 2, "R6", "reads for two distinct lines", LW'(n_req - base), LW'(2));
        chk(wait_mask == '0, "R8", "all merged threads awake", LW'(wait_mask), '0);

        // R9: every thread misses on its own line at once
        base = n_req;
        miss_v = '1;
        for (int i = 0; i < NT; i++) miss_l[i] = AW'(26'h0001000 + i * 26'h40);
        tick();
        miss_v = '0;
        repeat (24) tick();
        chk((n_req - base) == NT, "R9", "reads for full queue", LW'(n_req - base), LW'(NT));
        chk(wait_mask == '0, "R9", "queue drained", LW'(wait_mask), '0);

        // R3: a sleeping thread's second miss is ignored
        base = n_req;
        rsp_v = 1'b0;
        miss_v = 4'b0001; miss_l[0] = 26'h0002000;
        tick();
        miss_v = '0; repeat (2) tick();
        miss_v = 4'b0001; miss_l[0] = 26'h0002400;
        tick();
        miss_v = '0; rsp_v = 1'b1;
        repeat (10) tick();
        chk((n_req - base) == 1, "R3", "reads after repeat miss while asleep", LW'(n_req - base), LW'(1));

        // R8: a miss arriving in the wake cycle for the same line is released at once
        base = n_req;
        miss_v = 4'b0001; miss_l[0] = 26'h0003000;
        tick();
        miss_v = '0; tick(); tick();
        miss_v = 4'b0010; miss_l[1] = 26'h0003000;
        tick();
        chk(wait_mask[1] == 1'b0, "R8", "wake-cycle joiner asleep", LW'(wait_mask[1]), '0);
        miss_v = '0;
        repeat (6) tick();
        chk((n_req - base) == 1, "R8", "reads for wake-cycle join", LW'(n_req - base), LW'(1));

        // R7: response strobes outside the wait state do nothing
        rsp_v = 1'b1; req_rdy = 1'b0;
        repeat (5) tick();
        chk(!fill_valid, "R7", "fill with stray response", LW'(fill_valid), '0);

        // random traffic over a small line pool: merges of every kind
        for (int c = 0; c < 4000; c++) begin
            r1 = $urandom; r2 = $urandom;
            miss_v  = r1[3:0] & r2[3:0];
            for (int i = 0; i < NT; i++) miss_l[i] = pool[(r1[8 + 2*i +: 2] == 2'd3) ? 0 : r1[8 + 2*i +: 2]];
            en      = r2[7:4] | r2[11:8];
            full    = r2[15:12] & r2[19:16];
            req_rdy = r2[20];
            rsp_v   = (r2[23:22] == 2'd0);
            rand_rsp();
            tick();
        end
        miss_v = '0; req_rdy = 1'b1; rsp_v = 1'b1;
        repeat (40) tick();
        chk(wait_mask == '0, "R3,R8", "final drain", LW'(wait_mask), '0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule